// File: doc/BRIEF.md
# Tile-Pipelined Layer Stage Scheduler

This controller drives a folded accelerator in which one instance of each processing stage is shared by every tile of every layer. Each tile of a feature map passes through five stages in a fixed sequence: fetch from off-chip memory, 3x3 convolution, 1x1 convolution, pooling, and store back to off-chip memory. The scheduler gives each stage a one-cycle start pulse together with the layer and tile number it should work on. The stage then reports completion on its done line after any latency of one cycle or more.

Tiles of one layer do not depend on each other. The scheduler therefore lets the next tile enter a stage as soon as that stage is free. Several tiles are in flight at once, in different stages. When the last tile of a layer has been fetched, the fetch stage goes straight on with tile 0 of the next layer, so no barrier is needed between layers. Between each pair of adjacent stages sits a two-slot on-chip ping-pong buffer. The scheduler tracks how many slots of it are full and tells each stage which slot to read and which slot to write.

A run is launched with a start input, using a layer count and a tile count that both lie in the range 1 to 16. The run ends when the store stage reports done for the last tile of the last layer.

Top module: `tile_stage_sched`

## Requirements
- R1: During and after reset, `busy`, `finished` and every bit of `stg_start` are 0.
- R2: Every stage starts each (layer, tile) pair of the run exactly once, in strictly increasing lexicographic order: tile first runs from 0 to tiles-1, then the layer increments. Stage s uses bit s of `stg_start`, and field s (bits s*4 upward) of `stg_layer` and of `stg_tile`. Stage 0 is fetch and stage 4 is store.
- R3: A stage s > 0 starts an item only when the buffer ahead of it holds at least one item. An item counts as held once stage s-1 has reported done for it in an earlier cycle and stage s has not yet started it.
- R4: A stage s < 4 starts an item only when the buffer behind it holds fewer than two items, so no slot is overwritten before it has been consumed.
- R5: A stage is never started again until it has reported done for its current item. A start in the same cycle as that done is not allowed.
- R6: For a run with more than one item in total, the number of cycles from launch to `finished` is less than the serialized bound. That bound is 2 plus the sum, over all stage operations, of (latency + 1).
- R7: Tile 0 of the next layer can be fetched before the store stage has finished the last tile of the current layer.
- R8: `finished` rises, and `busy` falls, at the clock edge that samples the store done of the final item. `finished` then stays high until the next launch.
- R9: A `run_start` pulse that arrives while `busy` is high is ignored. The run in progress continues with its original configuration.
- R10: A done pulse on a stage that has no item in progress is ignored. It neither counts as a completion nor fills a buffer slot.
- R11: For the k-th item a stage starts in a run (k counted from 0 across layers), `stg_rd_slot` and `stg_wr_slot` of that stage both equal k mod 2 during the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_start | input | 1 | Launches a run when the scheduler is not busy |
| cfg_layers | input | 5 | Number of layers, 1 to 16 |
| cfg_tiles | input | 5 | Tiles per layer, 1 to 16 |
| stg_start | output | 5 | One-cycle start pulse, one bit per stage |
| stg_layer | output | 20 | Layer index of the started item, 4 bits per stage |
| stg_tile | output | 20 | Tile index of the started item, 4 bits per stage |
| stg_rd_slot | output | 5 | Input buffer slot each stage reads |
| stg_wr_slot | output | 5 | Output buffer slot each stage writes |
| stg_done | input | 5 | Completion pulse from each stage |
| busy | output | 1 | A run is in progress |
| finished | output | 1 | The last run has completed |

## Verification
The bench sweeps small layer and tile counts with random stage latencies, and also runs the largest configuration of 16 by 16.

A scheduler that let a stage start in the same cycle its done arrived would be caught by the one-item-per-stage check. One that ignored the downstream buffer count would start a stage while two items were still waiting, and the bench's own occupancy model would flag the overwrite. Counting a stray done pulse would make a consumer start on an empty buffer.

A layer barrier would make the next layer's first fetch wait for the previous layer's last store, which the cross-layer run detects. A scheduler that restarted on a mid-run start pulse would break the expected start order.

// File: rtl/tile_stage_sched.sv
module tile_stage_sched #(
  parameter int MAX_LAYERS = 16,
  parameter int MAX_TILES  = 16,
  localparam int LW = $clog2(MAX_LAYERS),
  localparam int TW = $clog2(MAX_TILES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_start,
  input  logic [LW:0]     cfg_layers,
  input  logic [TW:0]     cfg_tiles,
  output logic [4:0]      stg_start,
  output logic [5*LW-1:0] stg_layer,
  output logic [5*TW-1:0] stg_tile,
  output logic [4:0]      stg_rd_slot,
  output logic [4:0]      stg_wr_slot,
  input  logic [4:0]      stg_done,
  output logic            busy,
  output logic            finished
);
  localparam int NS = 5;
  localparam int KW = $clog2(MAX_LAYERS * MAX_TILES + 1);

  logic          run_q, fin_q, launch;
  logic [LW:0]   nl_q;
  logic [TW:0]   nt_q;
  logic [NS-1:0] sbusy, exh, go, dq;
  logic [KW-1:0] idx [NS];
  logic [1:0]    occ [NS-1];

  assign launch    = run_start & ~run_q;
  assign dq        = stg_done & sbusy;
  assign stg_start = go;
  assign busy      = run_q;
  assign finished  = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      nl_q  <= '0;
      nt_q  <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      fin_q <= 1'b0;
      nl_q  <= cfg_layers;
      nt_q  <= cfg_tiles;
    end else if (run_q && dq[NS-1] && exh[NS-1]) begin
      run_q <= 1'b0;
      fin_q <= 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < NS; s++) begin : g_stage
      logic          in_ok, out_ok, last_t, last_l;
      logic          busy_q, exh_q;
      logic [LW-1:0] lay_q;
      logic [TW-1:0] til_q;
      logic [KW-1:0] idx_q;

      if (s == 0) begin : g_head
        assign in_ok = 1'b1;
      end else begin : g_body_in
        assign in_ok = occ[s-1] != 2'd0;
      end
      if (s == NS-1) begin : g_tail
        assign out_ok = 1'b1;
      end else begin : g_body_out
        assign out_ok = occ[s] != 2'd2;
      end

      assign last_t = ({1'b0, til_q} + 1'b1) == nt_q;
      assign last_l = ({1'b0, lay_q} + 1'b1) == nl_q;
      assign go[s]  = run_q & ~busy_q & ~exh_q & in_ok & out_ok;

      assign sbusy[s] = busy_q;
      assign exh[s]   = exh_q;
      assign idx[s]   = idx_q;
      assign stg_layer[s*LW +: LW] = lay_q;
      assign stg_tile[s*TW +: TW]  = til_q;
      assign stg_rd_slot[s] = idx_q[0];
      assign stg_wr_slot[s] = idx_q[0];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q <= 1'b0;
          exh_q  <= 1'b0;
          lay_q  <= '0;
          til_q  <= '0;
          idx_q  <= '0;
        end else if (launch) begin
          busy_q <= 1'b0;
          exh_q  <= 1'b0;
          lay_q  <= '0;
          til_q  <= '0;
          idx_q  <= '0;
        end else if (go[s]) begin
          busy_q <= 1'b1;
          idx_q  <= idx_q + 1'b1;
          if (last_t) begin
            til_q <= '0;
            if (last_l) exh_q <= 1'b1;
            else        lay_q <= lay_q + 1'b1;
          end else begin
            til_q <= til_q + 1'b1;
          end
        end else if (dq[s]) begin
          busy_q <= 1'b0;
        end
      end

      p_one_item_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go[s] |=> !go[s]);
    end

    for (genvar s = 0; s < NS-1; s++) begin : g_link
      logic [1:0] occ_q;
      assign occ[s] = occ_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      occ_q <= 2'd0;
        else if (launch) occ_q <= 2'd0;
        else begin
          case ({dq[s], go[s+1]})
            2'b10:   occ_q <= occ_q + 2'd1;
            2'b01:   occ_q <= occ_q - 2'd1;
            default: occ_q <= occ_q;
          endcase
        end
      end

      p_slot_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 2'd2);
      p_behind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx[s+1] <= idx[s]);
      p_skew_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx[s] - idx[s+1]) <= KW'(3));
    end
  endgenerate

  p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finished) |-> $past(stg_done[NS-1]) && !busy);
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && run_start |=> $stable(nl_q) && $stable(nt_q));
endmodule

// File: tb/tile_stage_sched_tb_top.sv
module tile_stage_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;
  localparam int LW = 4;
  localparam int TW = 4;

  logic clk = 1'b0, rst_n = 1'b0, run_start = 1'b0;
  logic [4:0] cfg_layers = 5'd1, cfg_tiles = 5'd1;
  logic [4:0] stg_start, stg_rd_slot, stg_wr_slot;
  logic [4:0] done_r = '0, extra = '0;
  logic [19:0] stg_layer, stg_tile;
  logic busy, finished;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_stage_sched dut_i (
    .clk(clk), .rst_n(rst_n), .run_start(run_start),
    .cfg_layers(cfg_layers), .cfg_tiles(cfg_tiles),
    .stg_start(stg_start), .stg_layer(stg_layer), .stg_tile(stg_tile),
    .stg_rd_slot(stg_rd_slot), .stg_wr_slot(stg_wr_slot),
    .stg_done(done_r | extra), .busy(busy), .finished(finished)
  );

  int checks = 0, fails = 0;
  int rem [NS], exp_l [NS], exp_t [NS], kcnt [NS], bocc [NS-1];
  int run_l = 1, run_t = 1, lat_max = 3, lat_fixed = 0;
  int cyc = 0, wb_cnt = 0, last_cyc = 0, r7_load = 0, r7_wb = 0;
  longint cost = 0;
  bit spur = 0, final_seen = 0, model_on = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    logic [4:0] nd;
    int lt;
    cyc++;
    nd = '0;
    if (model_on) begin
      for (int s = 0; s < NS; s++)
        if (rem[s] > 0) begin
          rem[s]--;
          if (rem[s] == 0) nd[s] = 1'b1;
        end
      for (int s = 0; s < NS; s++)
        if (stg_start[s]) begin
          chk(rem[s] == 0 && !nd[s], "R5", rem[s], 0);
          chk(stg_layer[s*LW +: LW] == exp_l[s] && stg_tile[s*TW +: TW] == exp_t[s], "R2",
              stg_layer[s*LW +: LW] * 100 + stg_tile[s*TW +: TW], exp_l[s] * 100 + exp_t[s]);
          chk(stg_rd_slot[s] == kcnt[s][0] && stg_wr_slot[s] == kcnt[s][0], "R11",
              {stg_rd_slot[s], stg_wr_slot[s]}, {kcnt[s][0], kcnt[s][0]});
          if (s > 0)      chk(bocc[s-1] > 0, "R3", bocc[s-1], 1);
          if (s < NS - 1) chk(bocc[s] < 2, "R4", bocc[s], 1);
          if (s == 0 && exp_l[s] == 1 && exp_t[s] == 0) r7_load = cyc;
          lt = (lat_fixed > 0) ? lat_fixed : $urandom_range(1, lat_max);
          rem[s] = lt;
          cost += lt + 1;
          kcnt[s]++;
          if (exp_t[s] == run_t - 1) begin
            exp_t[s] = 0;
            exp_l[s]++;
          end else exp_t[s]++;
        end
      for (int s = 0; s < NS - 1; s++)
        bocc[s] += int'(nd[s]) - int'(stg_start[s+1]);
      if (nd[NS-1]) begin
        wb_cnt++;
        if (wb_cnt == run_t) r7_wb = cyc;
        if (wb_cnt == run_l * run_t) begin
          chk(busy && !finished, "R8", {busy, finished}, 2);
          final_seen = 1;
          last_cyc = cyc;
        end
      end
      if (spur && !nd[2] && rem[2] == 0 && !stg_start[2]) nd[2] = 1'b1;
    end
    done_r = nd;
  end

  task automatic do_run(input int nl, input int nt, input int lmax, input int lfix,
                        input bit sp, input bit interfere);
    int start_cyc, guard;
    @(posedge clk); #1;
    for (int s = 0; s < NS; s++) begin
      rem[s] = 0; exp_l[s] = 0; exp_t[s] = 0; kcnt[s] = 0;
    end
    for (int s = 0; s < NS - 1; s++) bocc[s] = 0;
    run_l = nl; run_t = nt; lat_max = lmax; lat_fixed = lfix; spur = sp;
    cost = 2; wb_cnt = 0; final_seen = 0; r7_load = 1000000; r7_wb = 0;
    cfg_layers = 5'(nl); cfg_tiles = 5'(nt);
    run_start = 1'b1;
    start_cyc = cyc;
    @(posedge clk); #1;
    run_start = 1'b0;
    if (interfere) begin
      repeat (5) @(posedge clk);
      #1;
      cfg_layers = 5'd1; cfg_tiles = 5'd1; run_start = 1'b1;
      @(posedge clk); #1;
      run_start = 1'b0;
    end
    guard = 0;
    while (!final_seen && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    spur = 0;
    chk(final_seen, "R8", final_seen, 1);
    @(negedge clk); #1;
    chk(finished && !busy, "R8", {busy, finished}, 1);
    for (int s = 0; s < NS; s++) chk(kcnt[s] == nl * nt, "R2", kcnt[s], nl * nt);
    if (nl * nt > 1) chk(longint'(last_cyc - start_cyc) < cost, "R6", last_cyc - start_cyc, cost);
    repeat (3) @(posedge clk);
    #1;
    chk(finished && !busy && stg_start == 0, "R8", {busy, finished, stg_start}, 32);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !finished && stg_start == 0, "R1", {busy, finished, stg_start}, 0);
    rst_n = 1'b1;
    model_on = 1;
    @(posedge clk); #1;
    chk(!busy && !finished && stg_start == 0, "R1", {busy, finished, stg_start}, 0);

    for (int l = 1; l <= 3; l++)
      for (int t = 1; t <= 4; t++)
        do_run(l, t, 3, 0, 0, 0);
    do_run(1, 1, 1, 1, 0, 0);
    do_run(16, 16, 4, 0, 0, 0);

    do_run(2, 4, 1, 1, 0, 0);
    chk(r7_load < r7_wb, "R7", r7_load, r7_wb);

    do_run(4, 4, 3, 0, 0, 1);

    do_run(3, 3, 4, 0, 1, 0);

    @(posedge clk); #1;
    extra = 5'h1f;
    @(posedge clk); #1;
    extra = 5'h00;
    chk(stg_start == 0 && finished && !busy, "R10", {busy, finished, stg_start}, 32);
    @(posedge clk); #1;
    chk(stg_start == 0 && finished && !busy, "R10", {busy, finished, stg_start}, 32);
    do_run(2, 3, 2, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule